// File: doc/BRIEF.md
# Eight-Operation Small ALU

A purely combinational arithmetic logic unit for two narrow unsigned operands. A 3-bit select code picks one of eight operations:

- add and subtract;
- bitwise AND, bitwise OR and NOT;
- one-bit left and right shifts;
- a three-way magnitude compare.

Each operation has its own sub-unit. A separate selector for each output bit takes that bit from the chosen sub-unit.

The operand width is the parameter `W`, with a default of 2 and a minimum of 2. The outputs are:

- a `W`-bit result bus;
- a carry/borrow/shift-out line;
- three comparison flags, greater, less and equal, which are valid whatever the select code is.

The block holds no state. Registers, instruction decoding and memory are outside it, and it is meant to sit between an accumulator and a working register of a small processor core.

Top module: `octo_alu`

## Requirements
- R1: Select code 3'b111 gives result = (A + B) mod 2^W, and `cy_out` is the carry out of the top bit.
- R2: Select code 3'b001 gives result = (A - B) mod 2^W in two's complement, and `cy_out` is 1 exactly when A < B as unsigned values.
- R3: Select code 3'b100 gives result = A AND B bit by bit, with `cy_out` = 0.
- R4: Select code 3'b101 gives result = A OR B bit by bit, with `cy_out` = 0.
- R5: Select code 3'b110 gives result = the bitwise inverse of A, with `cy_out` = 0. Operand B has no effect on any output except the three comparison flags.
- R6: Select code 3'b010 shifts A left by one bit. Bit 0 of the result is 0, and `cy_out` is the old A[W-1]. B has no effect on result or `cy_out`.
- R7: Select code 3'b011 shifts A right by one bit. Bit W-1 of the result is 0, and `cy_out` is the old A[0]. B has no effect on result or `cy_out`.
- R8: Select code 3'b000 compares A and B. The result bus is the value 1 for A > B, the value 2 for A < B and 0 for A = B, and `cy_out` = 0.
- R9: For every select code, `flag_gt`, `flag_lt` and `flag_eq` show A > B, A < B and A = B. Exactly one of the three is high.
- R10: Every output is a function of the present inputs only. It is valid in the same cycle the inputs are applied, and earlier inputs have no influence on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W | First operand, unsigned |
| opnd_b | input | W | Second operand, unsigned |
| op_sel | input | 3 | Operation select code |
| result | output | W | Selected operation's result |
| cy_out | output | 1 | Carry (add), borrow (subtract), shifted-out bit (shifts), else 0 |
| flag_gt | output | 1 | A greater than B |
| flag_lt | output | 1 | A less than B |
| flag_eq | output | 1 | A equal to B |

## Verification
Every result of this block is due zero cycles after its inputs change, because no register lies between the operand and select pins and the outputs. The bench applies each operand pair and select code on the falling clock edge and samples one nanosecond after the following rising edge. The outputs have therefore settled, and no edge ordering is involved. Sweeps run in different orders of select code and operand, so a result that depended on the previous input would show up as a mismatch.

// File: rtl/octo_alu_pkg.sv
`timescale 1ns/1ps
package octo_alu_pkg;

  typedef enum logic [2:0] {
    OP_CMP = 3'b000,
    OP_SUB = 3'b001,
    OP_SHL = 3'b010,
    OP_SHR = 3'b011,
    OP_AND = 3'b100,
    OP_OR  = 3'b101,
    OP_NOT = 3'b110,
    OP_ADD = 3'b111
  } alu_op_e;

  localparam int NUM_OPS = 8;

  // {carry, sum}
  function automatic logic [16:0] add_ext(input logic [15:0] a, input logic [15:0] b,
                                          input int unsigned w);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    // move the carry of width w into bit 16
    add_ext = {s[w], 16'(s[15:0] & ((17'h1 << w) - 17'h1))};
  endfunction

  // {borrow, difference}
  function automatic logic [16:0] sub_ext(input logic [15:0] a, input logic [15:0] b,
                                          input int unsigned w);
    logic [16:0] d;
    d = {1'b0, a} - {1'b0, b};
    sub_ext = {d[16], 16'(d[15:0] & ((17'h1 << w) - 17'h1))};
  endfunction

  // {lt, gt}, decided from the top bit down
  function automatic logic [1:0] mag_cmp(input logic [15:0] a, input logic [15:0] b,
                                         input int unsigned w);
    logic gt, lt;
    gt = 1'b0;
    lt = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      if (i < int'(w) && !gt && !lt) begin
        if (a[i] && !b[i]) gt = 1'b1;
        else if (!a[i] && b[i]) lt = 1'b1;
      end
    end
    mag_cmp = {lt, gt};
  endfunction

endpackage

// File: rtl/octo_alu_arith.sv
`timescale 1ns/1ps
module octo_alu_arith #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic [W-1:0] diff,
  output logic         borrow
);
  import octo_alu_pkg::*;

  logic [16:0] add_full;
  logic [16:0] sub_full;

  always_comb begin
    add_full = add_ext(16'(a), 16'(b), W);
    sub_full = sub_ext(16'(a), 16'(b), W);
  end

  assign sum    = add_full[W-1:0];
  assign carry  = add_full[16];
  assign diff   = sub_full[W-1:0];
  assign borrow = sub_full[16];

  logic unused_hi;
  assign unused_hi = ^{add_full[15:W], sub_full[15:W]};
endmodule

// File: rtl/octo_alu_logic.sv
`timescale 1ns/1ps
module octo_alu_logic #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_res,
  output logic [W-1:0] or_res,
  output logic [W-1:0] not_res,
  output logic [W-1:0] shl_res,
  output logic         shl_out,
  output logic [W-1:0] shr_res,
  output logic         shr_out
);
  assign and_res = a & b;
  assign or_res  = a | b;
  assign not_res = ~a;

  assign shl_res = {a[W-2:0], 1'b0};
  assign shl_out = a[W-1];
  assign shr_res = {1'b0, a[W-1:1]};
  assign shr_out = a[0];
endmodule

// File: rtl/octo_alu_cmp.sv
`timescale 1ns/1ps
module octo_alu_cmp #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         gt,
  output logic         lt,
  output logic         eq,
  output logic [W-1:0] code
);
  import octo_alu_pkg::*;

  logic [1:0] lg;
  always_comb lg = mag_cmp(16'(a), 16'(b), W);

  assign gt = lg[0];
  assign lt = lg[1];
  assign eq = ~(lg[0] | lg[1]);

  always_comb begin
    code    = '0;
    code[0] = lg[0];
    code[1] = lg[1];
  end
endmodule

// File: rtl/octo_alu_bitsel.sv
`timescale 1ns/1ps
module octo_alu_bitsel #(
  parameter int N  = 8,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  input  logic [SW-1:0] sel,
  output logic          y
);
  assign y = cand[sel];
endmodule

// File: rtl/octo_alu.sv
`timescale 1ns/1ps
module octo_alu #(
  parameter int W = 2
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [2:0]   op_sel,
  output logic [W-1:0] result,
  output logic         cy_out,
  output logic         flag_gt,
  output logic         flag_lt,
  output logic         flag_eq
);
  import octo_alu_pkg::*;

  // sub-unit outputs, named for the checker
  logic [W-1:0] add_sum, sub_diff, and_res, or_res, not_res, shl_res, shr_res, cmp_code;
  logic         add_cy, sub_bw, shl_out, shr_out;
  logic         cmp_gt, cmp_lt, cmp_eq;

  octo_alu_arith #(.W(W)) u_arith (
    .a(opnd_a), .b(opnd_b),
    .sum(add_sum), .carry(add_cy), .diff(sub_diff), .borrow(sub_bw)
  );

  octo_alu_logic #(.W(W)) u_logic (
    .a(opnd_a), .b(opnd_b),
    .and_res(and_res), .or_res(or_res), .not_res(not_res),
    .shl_res(shl_res), .shl_out(shl_out), .shr_res(shr_res), .shr_out(shr_out)
  );

  octo_alu_cmp #(.W(W)) u_cmp (
    .a(opnd_a), .b(opnd_b),
    .gt(cmp_gt), .lt(cmp_lt), .eq(cmp_eq), .code(cmp_code)
  );

  // one selector per result bit, one more for the carry line
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [NUM_OPS-1:0] cand;
    assign cand = {add_sum[i], not_res[i], or_res[i], and_res[i],
                   shr_res[i], shl_res[i], sub_diff[i], cmp_code[i]};
    octo_alu_bitsel #(.N(NUM_OPS)) u_sel (
      .cand(cand), .sel(op_sel), .y(result[i])
    );
  end

  logic [NUM_OPS-1:0] cy_cand;
  assign cy_cand = {add_cy, 1'b0, 1'b0, 1'b0, shr_out, shl_out, sub_bw, 1'b0};
  octo_alu_bitsel #(.N(NUM_OPS)) u_cy_sel (
    .cand(cy_cand), .sel(op_sel), .y(cy_out)
  );

  assign flag_gt = cmp_gt;
  assign flag_lt = cmp_lt;
  assign flag_eq = cmp_eq;
endmodule

// File: rtl/octo_alu_chk.sv
`timescale 1ns/1ps
module octo_alu_chk #(
  parameter int W = 2
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [2:0]   op_sel,
  input logic [W-1:0] result,
  input logic         cy_out,
  input logic         flag_gt,
  input logic         flag_lt,
  input logic         flag_eq,
  input logic         add_cy,
  input logic [W-1:0] add_sum
);
  import octo_alu_pkg::*;

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, op_sel})) begin
      a_r9_one_flag: assert ($countones({flag_gt, flag_lt, flag_eq}) == 1)
        else $error("R9 flags not one-hot");
      if (op_sel == OP_SUB) begin
        a_r2_borrow_is_lt: assert (cy_out == flag_lt)
          else $error("R2 borrow disagrees with compare");
      end
      if (op_sel == OP_ADD) begin
        a_r1_add_total: assert ({add_cy, add_sum} == ({1'b0, opnd_a} + {1'b0, opnd_b}))
          else $error("R1 adder total wrong");
      end
      if (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_NOT || op_sel == OP_CMP) begin
        a_r10_cy_quiet: assert (!cy_out)
          else $error("R3/R4/R5/R8 carry line not zero");
      end
      if (op_sel == OP_NOT) begin
        a_r5_not_inverse: assert ((result ^ opnd_a) == {W{1'b1}})
          else $error("R5 result not inverse of A");
      end
      if (op_sel == OP_SHL) begin
        a_r6_shl_fill: assert (!result[0] && cy_out == opnd_a[W-1])
          else $error("R6 left shift fill/out wrong");
      end
      if (op_sel == OP_CMP) begin
        a_r8_cmp_code: assert (result[0] == flag_gt && result[1] == flag_lt)
          else $error("R8 compare code disagrees with flags");
      end
    end
  end
endmodule

bind octo_alu octo_alu_chk #(.W(W)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .result(result),
  .cy_out(cy_out), .flag_gt(flag_gt), .flag_lt(flag_lt), .flag_eq(flag_eq),
  .add_cy(add_cy), .add_sum(add_sum)
);

// File: tb/octo_alu_tb.sv
`timescale 1ns/1ps
module octo_alu_tb;
  localparam int W = 2;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [2:0]   op;
  logic         cy, gt, lt, eq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  octo_alu #(.W(W)) u_dut (
    .opnd_a(a), .opnd_b(b), .op_sel(op), .result(res),
    .cy_out(cy), .flag_gt(gt), .flag_lt(lt), .flag_eq(eq)
  );

  // independent reference: {cy, result} as an integer pair
  function automatic void ref_calc(input int o, input int x, input int y,
                                   output int r, output int c);
    c = 0;
    case (o)
      7: begin r = (x + y) % M; c = (x + y >= M) ? 1 : 0; end
      1: begin r = (x - y + M) % M; c = (x < y) ? 1 : 0; end
      4: r = x & y;
      5: r = x | y;
      6: r = M - 1 - x;
      2: begin r = (x * 2) % M; c = (x >= M / 2) ? 1 : 0; end
      3: begin r = x / 2; c = x % 2; end
      default: r = (x > y) ? 1 : ((x < y) ? 2 : 0);
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%0d b=%0d got=%0d exp=%0d", tag, op, a, b, got, exp);
    end
  endtask

  // result due in the same cycle: drive on falling edge, sample after rising edge
  task automatic apply(input int o, input int x, input int y);
    @(negedge clk);
    op = 3'(o); a = W'(x); b = W'(y);
    @(posedge clk);
    #1;
  endtask

  task automatic sweep_op(input int o, input string tag);
    int r, c;
    for (int x = 0; x < M; x++) begin
      for (int y = 0; y < M; y++) begin
        apply(o, x, y);
        ref_calc(o, x, y, r, c);
        check({tag, " result"}, int'(res), r);
        check({tag, " cy_out"}, int'(cy), c);
      end
    end
  endtask

  task automatic t_reset_state;
    // inputs held at zero through reset: compare of equal operands
    check("R8 reset result", int'(res), 0);
    check("R8 reset cy_out", int'(cy), 0);
    check("R9 reset eq", int'(eq), 1);
  endtask

  task automatic t_ops;
    sweep_op(7, "R1 add");
    sweep_op(1, "R2 sub");
    sweep_op(4, "R3 and");
    sweep_op(5, "R4 or");
    sweep_op(6, "R5 not");
    sweep_op(2, "R6 shl");
    sweep_op(3, "R7 shr");
    sweep_op(0, "R8 cmp");
  endtask

  task automatic t_b_ignored;
    // NOT and shifts: sweep B with A fixed, output must not move
    int r, c;
    int ops[3] = '{6, 2, 3};
    for (int k = 0; k < 3; k++) begin
      for (int y = 0; y < M; y++) begin
        apply(ops[k], M - 1, y);
        ref_calc(ops[k], M - 1, 0, r, c);
        check("R5/R6/R7 B ignored result", int'(res), r);
        check("R5/R6/R7 B ignored cy_out", int'(cy), c);
      end
    end
  endtask

  task automatic t_flags;
    for (int o = 0; o < 8; o++) begin
      for (int x = 0; x < M; x++) begin
        for (int y = 0; y < M; y++) begin
          apply(o, x, y);
          check("R9 gt", int'(gt), (x > y) ? 1 : 0);
          check("R9 lt", int'(lt), (x < y) ? 1 : 0);
          check("R9 eq", int'(eq), (x == y) ? 1 : 0);
        end
      end
    end
  endtask

  task automatic t_history;
    // R10: same inputs after different predecessors give the same outputs
    int r, c;
    ref_calc(7, M - 1, 1, r, c);
    apply(1, 0, M - 1);
    apply(7, M - 1, 1);
    check("R10 after sub result", int'(res), r);
    check("R10 after sub cy_out", int'(cy), c);
    apply(2, M - 1, M - 1);
    apply(7, M - 1, 1);
    check("R10 after shl result", int'(res), r);
    check("R10 after shl cy_out", int'(cy), c);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    op = 3'b000; a = '0; b = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset_state();
    rst_n = 1'b1;
    t_ops();
    t_b_ignored();
    t_flags();
    t_history();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule